// File: doc/BRIEF.md
# Reset cause status register

This block is a single memory-mapped 32-bit register that tells software why the chip last came out of reset. It also holds the enable and ready bits of a low-speed internal oscillator. Seven hardware event pulses set sticky cause flags: brownout, pin, power-on, software, independent watchdog, window watchdog and low-power management. A flag stays set until software writes a one to the remove-flags bit. That write clears every flag in one go.

The register spans two reset domains. The cause flags are reset only by the power-on reset, so they survive any later system reset. The oscillator enable, the oscillator settling logic and the bus wait-state logic are reset by either reset. The bus port is a word-wide read/write port with byte enables and an acknowledge. An access that follows straight after another one is stretched by wait states. The oscillator is modelled as a tick input, with one pulse per oscillator cycle, and a settling counter that produces the ready bit.

Top module: `rstcause_csr`

## Requirements
- R1: After a power-on reset the register reads 0x0E00_0000: flags at bits 27 (power-on), 26 (pin) and 25 (brownout) are 1, all other bits are 0, and `osc_en` is 0.
- R2: A pulse on `rst_evt[i]` (0 brownout, 1 pin, 2 power-on, 3 software, 4 independent watchdog, 5 window watchdog, 6 low-power) sets register bit 25+i at the next clock edge, and that bit stays set afterwards.
- R3: A system reset clears the enable (bit 0) and the ready (bit 1) bits but leaves bits 31:25 unchanged.
- R4: An acknowledged write with `bus_be[3]`=1 and data bit 24 = 1 clears bits 31:25 at that edge. Bit 24 always reads 0.
- R5: If a cause event arrives in the same cycle as a remove-flags write, the event's flag is set after that edge.
- R6: Bus writes never set or clear bits 31:25 directly. Writing ones or zeros there with bit 24 = 0 leaves the flags as they were.
- R7: An acknowledged write with `bus_be[0]`=1 loads data bit 0 into the enable bit, which reads back at bit 0 and drives `osc_en`.
- R8: The ready bit (bit 1) rises on the RISE_TICKS-th (default 8) `osc_tick` pulse after enable is set, and falls on the FALL_TICKS-th (default 6) pulse after enable is cleared. It changes only on a tick.
- R9: Bit 1 ignores writes, and bits 23:2 read 0 whatever is written to them.
- R10: `bus_ack` comes in the same cycle as `bus_req` when no access completed in the previous SUCC_WAIT (default 3) cycles. A request raised in the cycle right after an acknowledge waits exactly SUCC_WAIT cycles.
- R11: Byte enables gate writes: without `bus_be[3]` the remove bit has no effect, and without `bus_be[0]` the enable bit is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, resets everything |
| sys_rst_n | input | 1 | System reset, active low, spares the cause flags |
| rst_evt | input | 7 | Reset cause event pulses, one per flag |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables, bit n covers data bits 8n+7:8n |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Current register value |
| bus_ack | output | 1 | Access completes at this clock edge |
| osc_tick | input | 1 | One pulse per low-speed oscillator cycle |
| osc_en | output | 1 | Oscillator enable |

## Verification
The flags are set one cause at a time and read after each pulse. This shows that each event maps to its own bit and that earlier flags remain set. Writes of all-ones, all-zeros and a masked remove command tell the one legal clear path apart from ignored flag writes and from byte-enable gating. A remove write made while a software-reset event is held shows the event-wins ordering. The oscillator is given tick counts one short of and exactly at the rise and fall lengths, which pins both settling thresholds. Back-to-back accesses, compared with an access after idle, measure the wait-state count.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;

  localparam int REG_W    = 32;
  localparam int N_FLAGS  = 7;
  localparam int FLAG_LSB = 25;
  localparam int RMV_BIT  = 24;
  localparam int RDY_BIT  = 1;
  localparam int EN_BIT   = 0;

  // flags set by power-on: power-on (2), pin (1), brownout (0)
  localparam logic [N_FLAGS-1:0] FLAG_POR_INIT = 7'b000_0111;

  // Assemble the visible register value from its live fields.
  function automatic logic [REG_W-1:0] pack_csr(input logic [N_FLAGS-1:0] flags,
                                                input logic en,
                                                input logic rdy);
    logic [REG_W-1:0] v;
    v = '0;
    v[FLAG_LSB +: N_FLAGS] = flags;
    v[RDY_BIT] = rdy;
    v[EN_BIT]  = en;
    return v;
  endfunction

  // Number of oscillator ticks needed to move ready toward enable.
  function automatic int settle_len(input logic en, input int rise, input int fall);
    return en ? rise : fall;
  endfunction

  // Next value of the sticky flags: a clear is overridden by same-cycle events.
  function automatic logic [N_FLAGS-1:0] next_flags(input logic [N_FLAGS-1:0] cur,
                                                    input logic clr,
                                                    input logic [N_FLAGS-1:0] evt);
    return (clr ? '0 : cur) | evt;
  endfunction

endpackage

// File: rtl/csr_bus_port.sv
module csr_bus_port
  import rstcause_pkg::*;
#(
  parameter int SUCC_WAIT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       we,
  input  logic [3:0] be,
  input  logic       rmv_data,
  input  logic       en_data,
  output logic       ack,
  output logic       clr_flags,
  output logic       en_wr,
  output logic       en_wdata
);

  localparam int WW = $clog2(SUCC_WAIT + 2);

  logic [WW-1:0] wcnt;

  assign ack       = req && (wcnt == '0);
  assign clr_flags = ack && we && be[RMV_BIT/8] && rmv_data;
  assign en_wr     = ack && we && be[EN_BIT/8];
  assign en_wdata  = en_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
    end else if (ack) begin
      wcnt <= WW'(SUCC_WAIT);
    end else if (wcnt != '0) begin
      wcnt <= wcnt - 1'b1;
    end
  end

endmodule

// File: rtl/rstcause_flags.sv
module rstcause_flags
  import rstcause_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  logic [N_FLAGS-1:0] evt,
  input  logic               clr,
  output logic [N_FLAGS-1:0] flags
);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flags <= FLAG_POR_INIT;
    end else begin
      flags <= next_flags(flags, clr, evt);
    end
  end

endmodule

// File: rtl/lsosc_settle.sv
module lsosc_settle
  import rstcause_pkg::*;
#(
  parameter int RISE_TICKS = 8,
  parameter int FALL_TICKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic rdy
);

  localparam int MAXT = (RISE_TICKS > FALL_TICKS) ? RISE_TICKS : FALL_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = CW'(settle_len(en, RISE_TICKS, FALL_TICKS) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      rdy <= 1'b0;
    end else if (en == rdy) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == last) begin
        rdy <= en;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rstcause_csr.sv
module rstcause_csr
  import rstcause_pkg::*;
#(
  parameter int RISE_TICKS = 8,
  parameter int FALL_TICKS = 6,
  parameter int SUCC_WAIT  = 3
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               sys_rst_n,
  input  logic [N_FLAGS-1:0] rst_evt,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [3:0]         bus_be,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               bus_ack,
  input  logic               osc_tick,
  output logic               osc_en
);

  // system domain: cleared by either reset
  logic sys_n;
  assign sys_n = sys_rst_n & por_n;

  // named internal events
  logic               clr_flags;
  logic               en_wr;
  logic               en_wdata;
  logic [N_FLAGS-1:0] flags;
  logic               osc_rdy;
  logic               en_q;

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[REG_W-1:RMV_BIT+1], bus_wdata[RMV_BIT-1:EN_BIT+1],
                          bus_be[2:1]};

  csr_bus_port #(.SUCC_WAIT(SUCC_WAIT)) u_bus (
    .clk      (clk),
    .rst_n    (sys_n),
    .req      (bus_req),
    .we       (bus_we),
    .be       (bus_be),
    .rmv_data (bus_wdata[RMV_BIT]),
    .en_data  (bus_wdata[EN_BIT]),
    .ack      (bus_ack),
    .clr_flags(clr_flags),
    .en_wr    (en_wr),
    .en_wdata (en_wdata)
  );

  rstcause_flags u_flags (
    .clk  (clk),
    .por_n(por_n),
    .evt  (rst_evt),
    .clr  (clr_flags),
    .flags(flags)
  );

  always_ff @(posedge clk or negedge sys_n) begin
    if (!sys_n) begin
      en_q <= 1'b0;
    end else if (en_wr) begin
      en_q <= en_wdata;
    end
  end

  lsosc_settle #(.RISE_TICKS(RISE_TICKS), .FALL_TICKS(FALL_TICKS)) u_settle (
    .clk  (clk),
    .rst_n(sys_n),
    .en   (en_q),
    .tick (osc_tick),
    .rdy  (osc_rdy)
  );

  assign osc_en    = en_q;
  assign bus_rdata = pack_csr(flags, en_q, osc_rdy);

endmodule

// File: rtl/rstcause_csr_chk.sv
module rstcause_csr_chk
  import rstcause_pkg::*;
#(
  parameter int SUCC_WAIT = 3
) (
  input logic               clk,
  input logic               por_n,
  input logic               sys_n,
  input logic [N_FLAGS-1:0] rst_evt,
  input logic [N_FLAGS-1:0] flags,
  input logic               clr_flags,
  input logic               en_wr,
  input logic               en_wdata,
  input logic               osc_en,
  input logic               osc_rdy,
  input logic               osc_tick,
  input logic               bus_ack,
  input logic [REG_W-1:0]   bus_rdata
);

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!por_n)
    (rst_evt != '0) |=> ((flags & $past(rst_evt)) == $past(rst_evt)));

  p_rmv_clears_r4: assert property (@(posedge clk) disable iff (!por_n)
    (clr_flags && rst_evt == '0) |=> (flags == '0));

  p_rmv_event_wins_r5: assert property (@(posedge clk) disable iff (!por_n)
    clr_flags |=> (flags == $past(rst_evt)));

  // R3 and R6: without a clear or an event the flags hold, system reset or not
  p_flags_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
    (!clr_flags && rst_evt == '0) |=> $stable(flags));

  p_en_load_r7: assert property (@(posedge clk) disable iff (!sys_n)
    en_wr |=> (osc_en == $past(en_wdata)));

  p_rdy_on_tick_r8: assert property (@(posedge clk) disable iff (!sys_n)
    (osc_rdy != $past(osc_rdy)) |-> $past(osc_tick));

  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!por_n)
    (bus_rdata[RMV_BIT:RDY_BIT+1] == '0));

  generate
    if (SUCC_WAIT > 0) begin : g_wait
      p_no_back2back_r10: assert property (@(posedge clk) disable iff (!sys_n)
        bus_ack |=> !bus_ack);
    end
  endgenerate

endmodule

bind rstcause_csr rstcause_csr_chk #(.SUCC_WAIT(SUCC_WAIT)) u_chk (
  .clk      (clk),
  .por_n    (por_n),
  .sys_n    (sys_n),
  .rst_evt  (rst_evt),
  .flags    (flags),
  .clr_flags(clr_flags),
  .en_wr    (en_wr),
  .en_wdata (en_wdata),
  .osc_en   (osc_en),
  .osc_rdy  (osc_rdy),
  .osc_tick (osc_tick),
  .bus_ack  (bus_ack),
  .bus_rdata(bus_rdata)
);

// File: tb/rstcause_csr_bench.sv
module rstcause_csr_bench;

  localparam int RISE = 8;
  localparam int FALL = 6;
  localparam int WAITS = 3;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic [6:0]  rst_evt = '0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic        osc_tick = 1'b0;
  logic        osc_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  rstcause_csr #(.RISE_TICKS(RISE), .FALL_TICKS(FALL), .SUCC_WAIT(WAITS)) u_rstcause_csr (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .rst_evt(rst_evt),
    .bus_req(bus_req), .bus_we(bus_we), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .osc_tick(osc_tick), .osc_en(osc_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when a read completes
  always begin
    @(negedge clk);
    #1;
    if (bus_req && !bus_we && bus_ack) begin
      if (exp_q.size() == 0) begin
        chk("monitor unexpected read", bus_rdata, 32'hxxxx_xxxx);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic bus_access(input logic we, input logic [3:0] be,
                            input logic [31:0] wd, output int waits);
    waits = 0;
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_be = be; bus_wdata = wd;
    forever begin
      #1;
      if (bus_ack) break;
      waits++;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    bus_req = 1'b0; bus_we = 1'b0; bus_be = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [31:0] exp, input string tag);
    int w;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_access(1'b0, 4'h0, 32'h0, w);
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] wd);
    int w;
    bus_access(1'b1, be, wd, w);
  endtask

  task automatic pulse_evt(input logic [6:0] v);
    @(negedge clk); rst_evt = v;
    @(negedge clk); rst_evt = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick = 1'b1;
      @(negedge clk); osc_tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int w;
    logic [31:0] acc;
    repeat (4) @(negedge clk);
    por_n = 1'b1; sys_rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset value, R10 idle access acked at once
    chk("R1 osc_en after power-on", {31'b0, osc_en}, 32'h0);
    exp_q.push_back(32'h0E00_0000); tag_q.push_back("R1 power-on value");
    bus_access(1'b0, 4'h0, 32'h0, w);
    chk("R10 waits after idle", w, 0);

    // R4 remove flags, back-to-back access waits SUCC_WAIT
    bus_access(1'b1, 4'b1000, 32'h0100_0000, w);
    chk("R10 waits back-to-back", w, WAITS);
    rd(32'h0000_0000, "R4 flags removed, bit24 reads 0");

    // R2 each cause sets its own bit, earlier bits stay
    acc = '0;
    for (int i = 0; i < 7; i++) begin
      pulse_evt(7'(1 << i));
      acc = acc | (32'h1 << (25 + i));
      rd(acc, $sformatf("R2 cause %0d", i));
    end
    wr(4'b1000, 32'h0100_0000);
    rd(32'h0, "R4 clear all seven");

    // R6 flag bits ignore direct writes
    pulse_evt(7'b100_0001);
    wr(4'hF, 32'h7C00_0000);
    rd(32'h8200_0000, "R6 write ones to flags");
    wr(4'hF, 32'h0000_0000);
    rd(32'h8200_0000, "R6 write zeros to flags");

    // R11 remove without lane 3 enable
    wr(4'b0111, 32'h0100_0000);
    rd(32'h8200_0000, "R11 remove masked by be3");

    // R5 event in the same cycle as remove
    @(negedge clk); rst_evt = 7'b000_1000;
    wr(4'b1000, 32'h0100_0000);
    rst_evt = '0;
    rd(32'h1000_0000, "R5 event wins over remove");

    // R7 enable, R3 system reset keeps flags
    wr(4'b0001, 32'h0000_0001);
    chk("R7 osc_en set", {31'b0, osc_en}, 32'h1);
    rd(32'h1000_0001, "R7 enable reads back");
    @(negedge clk); sys_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 osc_en in system reset", {31'b0, osc_en}, 32'h0);
    sys_rst_n = 1'b1;
    rd(32'h1000_0000, "R3 flags kept over system reset");

    // R8 settling thresholds
    wr(4'b0001, 32'h0000_0001);
    ticks(RISE - 1);
    rd(32'h1000_0001, "R8 not ready one tick short");
    ticks(1);
    rd(32'h1000_0003, "R8 ready after rise ticks");
    wr(4'b0001, 32'h0000_0000);
    rd(32'h1000_0002, "R8 ready holds after disable");
    ticks(FALL - 1);
    rd(32'h1000_0002, "R8 still ready one tick short");
    ticks(1);
    rd(32'h1000_0000, "R8 ready falls after fall ticks");

    // R9 reserved and read-only bits
    wr(4'hF, 32'h00FF_FFFE);
    rd(32'h1000_0000, "R9 reserved and ready ignore writes");

    // R11 enable masked by be0
    wr(4'b1110, 32'h0000_0001);
    chk("R11 osc_en unchanged", {31'b0, osc_en}, 32'h0);
    rd(32'h1000_0000, "R11 enable masked by be0");

    // R1 again after a later power-on
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(32'h0E00_0000, "R1 value after second power-on");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end

endmodule